// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Edge and Center Alignment

This block produces one pulse-width-modulated output from a master clock. A clock selector chooses how often the channel counter advances. It can use one of eleven power-of-two prescaler taps, or one of two linear dividers that each count ticks from a tap of their own choosing. The channel advance is a single-cycle enable strobe in the master clock domain. No derived clock is created.

The period counter runs in one of two modes. Edge-aligned mode counts up and wraps. Center-aligned mode counts up and then back down, which doubles the period and keeps the active pulse centred. Two channels in center mode can therefore be given non-overlapping pulses. A duty threshold and a start-level bit shape the output. Period, duty, start level and alignment are held in shadow registers, which take a new value only when a period ends, so a mid-period write never causes a glitch. A one-cycle marker flags the start of each new period.

Top module: `pwm_channel`

## Requirements
- R1: While `rst` is high, and after reset with `cfg_en` low and `cfg_pol` low, `pwm_out` is 0 and `period_start` is 0.
- R2: With `cfg_csel` = k, where k is from 0 to 10, the counter advances once every 2^k master cycles. An edge-aligned period then lasts 2^k·P master cycles, where P is `cfg_period`.
- R3: `cfg_csel` = 11 selects divider A and 12 selects divider B. A divider with tap select t and divide value N advances the counter every 2^t·N cycles. A divide value of 0, or `cfg_csel` of 13 to 15, gives no advance and no `period_start`.
- R4: Edge-aligned mode (`cfg_center` = 0) counts 0 to P−1 and wraps, so a period is P ticks. The output sits at the start level while count < D, where D is `cfg_duty`, and at the opposite level for the remaining P−D ticks.
- R5: Center-aligned mode (`cfg_center` = 1) counts 0 up to P−1, holds that value for one further tick while turning, and counts back down to 0. A period is 2·P ticks, and the opposite level lasts 2·(P−D) ticks.
- R6: `cfg_pol` gives the start level. The output takes this level at the start of each period when D > 0.
- R7: Changes to period, duty, start level and alignment made while running take effect only at the next period boundary.
- R8: With `cfg_en` low, the counter is held at zero, `period_start` stays 0, and `pwm_out` equals `cfg_pol` as captured one cycle earlier.
- R9: D = 0 keeps the output constant at the opposite level, and D ≥ P keeps it constant at the start level, with no glitch at the boundary.
- R10: `period_start` is high for one cycle, in the cycle in which the counter has just returned to zero for a new period. It is not raised when the channel is enabled.
- R11: A `cfg_period` of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Channel run enable |
| cfg_csel | input | 4 | Tick source: 0–10 taps, 11 divider A, 12 divider B |
| cfg_diva_tap | input | 4 | Prescaler tap feeding divider A |
| cfg_diva | input | 8 | Divide value of divider A |
| cfg_divb_tap | input | 4 | Prescaler tap feeding divider B |
| cfg_divb | input | 8 | Divide value of divider B |
| cfg_period | input | 16 | Period in ticks |
| cfg_duty | input | 16 | Duty threshold in ticks |
| cfg_pol | input | 1 | Start-of-period output level |
| cfg_center | input | 1 | 1 selects center-aligned counting |
| pwm_out | output | 1 | Modulated output |
| period_start | output | 1 | One-cycle new-period marker |

## Verification
The assertions assume three things about the inputs. Reset is applied before the first configuration. The tap and divider settings stay stable while a divider is mid-count. Any mid-run write lands at least one tick before the boundary at which it is meant to appear. The stimulus keeps to these limits. It reconfigures the clock source only while the channel is disabled, and it drives every input on the falling edge. In the shadow test it writes the new period two cycles into a six-tick period, well clear of the wrap. Each expected period length and active-level count comes from the tick arithmetic in the requirements. These values are compared with the time measured between successive period markers.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        SRC_TAP  = 2'd0,
        SRC_DIVA = 2'd1,
        SRC_DIVB = 2'd2,
        SRC_OFF  = 2'd3
    } src_e;

    typedef enum logic {
        ALIGN_EDGE   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Map a clock-select code onto its tick source.
    function automatic src_e src_of(input logic [7:0] sel, input int ntaps);
        if (int'(sel) < ntaps)       return SRC_TAP;
        else if (int'(sel) == ntaps) return SRC_DIVA;
        else if (int'(sel) == ntaps + 1) return SRC_DIVB;
        else                         return SRC_OFF;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int NTAPS = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [NTAPS-1:0] tap
);
    localparam int PW = (NTAPS > 1) ? NTAPS - 1 : 1;

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    // Tap k strobes once every 2^k cycles.
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        if (k == 0) begin : g_t0
            assign tap[k] = run;
        end else begin : g_tk
            assign tap[k] = run && (&pcnt[k-1:0]);

            // R2: a slower tap only fires together with the next faster one
            a_r2_tap_nested: assert property (@(posedge clk) disable iff (rst)
                tap[k] |-> tap[k-1]);
        end
    end

endmodule

// File: rtl/pwm_lindiv.sv
module pwm_lindiv #(
    parameter int NTAPS = 11,
    parameter int DIV_W = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [NTAPS-1:0] tap,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    logic [DIV_W-1:0] dcnt;
    logic             src_tick;
    logic             at_end;

    always_comb begin
        if (int'(tap_sel) < NTAPS) src_tick = tap[tap_sel];
        else                       src_tick = 1'b0;
    end

    assign at_end = (dcnt >= div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || div == '0) begin
            dcnt <= '0;
        end else if (src_tick) begin
            dcnt <= at_end ? '0 : dcnt + 1'b1;
        end
    end

    assign strobe = run && src_tick && (div != '0) && at_end;

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_pkg::*;
#(
    parameter int NTAPS = 11,
    parameter int DIV_W = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] csel,
    input  logic [SEL_W-1:0] a_tap,
    input  logic [DIV_W-1:0] a_div,
    input  logic [SEL_W-1:0] b_tap,
    input  logic [DIV_W-1:0] b_div,
    output logic             tick
);
    localparam int NLIN = 2;

    logic [NTAPS-1:0] tap;
    logic [NLIN-1:0]  lin;
    logic [SEL_W-1:0] lin_tap [NLIN];
    logic [DIV_W-1:0] lin_div [NLIN];

    assign lin_tap[0] = a_tap;
    assign lin_tap[1] = b_tap;
    assign lin_div[0] = a_div;
    assign lin_div[1] = b_div;

    pwm_prescale #(.NTAPS(NTAPS)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tap (tap)
    );

    for (genvar i = 0; i < NLIN; i++) begin : g_lin
        pwm_lindiv #(.NTAPS(NTAPS), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_div (
            .clk     (clk),
            .rst     (rst),
            .run     (run),
            .tap     (tap),
            .tap_sel (lin_tap[i]),
            .div     (lin_div[i]),
            .strobe  (lin[i])
        );
    end

    always_comb begin
        case (src_of(8'(csel), NTAPS))
            SRC_TAP:  tick = tap[csel];
            SRC_DIVA: tick = lin[0];
            SRC_DIVB: tick = lin[1];
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty,
    input  logic             cfg_pol,
    input  logic             cfg_center,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_sh,
    output logic             pol_sh,
    output logic             run_q,
    output logic             bnd
);
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] last_v;
    align_e           align_sh;
    dir_e             dir;
    logic             wrap;

    assign last_v = (per_sh == '0) ? '0 : per_sh - 1'b1;

    always_comb begin
        if (align_sh == ALIGN_EDGE) wrap = tick && (cnt >= last_v);
        else                        wrap = tick && (dir == DIR_DOWN) && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            dir      <= DIR_UP;
            per_sh   <= '0;
            duty_sh  <= '0;
            pol_sh   <= 1'b0;
            align_sh <= ALIGN_EDGE;
            run_q    <= 1'b0;
            bnd      <= 1'b0;
        end else begin
            run_q <= run;
            bnd   <= 1'b0;
            if (!run || wrap) begin
                cnt      <= '0;
                dir      <= DIR_UP;
                per_sh   <= cfg_period;
                duty_sh  <= cfg_duty;
                pol_sh   <= cfg_pol;
                align_sh <= align_e'(cfg_center);
                bnd      <= run;
            end else if (tick) begin
                if (align_sh == ALIGN_EDGE) begin
                    cnt <= cnt + 1'b1;
                end else if (dir == DIR_UP) begin
                    if (cnt >= last_v) dir <= DIR_DOWN;
                    else               cnt <= cnt + 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R4: the count never passes the last value of the loaded period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run_q |-> cnt <= last_v);

    // R10: a boundary marker always coincides with a zero count
    a_r10_bnd_at_zero: assert property (@(posedge clk) disable iff (rst)
        bnd |-> (cnt == '0 && run_q));

    // R8: a disabled channel holds zero and raises no marker
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && !bnd));

    // R7: shadows hold between boundaries while running
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> ($stable(per_sh) && $stable(duty_sh) &&
                            $stable(pol_sh) && $stable(align_sh)));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_q,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_sh,
    input  logic             pol_sh,
    output logic             pwm_out
);
    logic active;

    assign active  = run_q && (cnt >= duty_sh);
    assign pwm_out = active ? ~pol_sh : pol_sh;

    // R9: a zero threshold with steady shadows gives a steady output
    a_r9_no_glitch: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && duty_sh == '0 &&
         $stable(duty_sh) && $stable(pol_sh)) |-> $stable(pwm_out));

    // R6: the start of a period shows the start level when duty is nonzero
    a_r6_start_level: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt == '0 && duty_sh != '0) |-> (pwm_out == pol_sh));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int  NTAPS = 11,
    parameter int  DIV_W = 8,
    parameter int  CNT_W = 16,
    localparam int SEL_W = $clog2(NTAPS + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic [SEL_W-1:0] cfg_csel,
    input  logic [SEL_W-1:0] cfg_diva_tap,
    input  logic [DIV_W-1:0] cfg_diva,
    input  logic [SEL_W-1:0] cfg_divb_tap,
    input  logic [DIV_W-1:0] cfg_divb,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty,
    input  logic             cfg_pol,
    input  logic             cfg_center,
    output logic             pwm_out,
    output logic             period_start
);
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_sh;
    logic             pol_sh;
    logic             run_q;

    pwm_tick_gen #(.NTAPS(NTAPS), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .run   (cfg_en),
        .csel  (cfg_csel),
        .a_tap (cfg_diva_tap),
        .a_div (cfg_diva),
        .b_tap (cfg_divb_tap),
        .b_div (cfg_divb),
        .tick  (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg_en),
        .tick       (tick),
        .cfg_period (cfg_period),
        .cfg_duty   (cfg_duty),
        .cfg_pol    (cfg_pol),
        .cfg_center (cfg_center),
        .cnt        (cnt),
        .duty_sh    (duty_sh),
        .pol_sh     (pol_sh),
        .run_q      (run_q),
        .bnd        (period_start)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .run_q   (run_q),
        .cnt     (cnt),
        .duty_sh (duty_sh),
        .pol_sh  (pol_sh),
        .pwm_out (pwm_out)
    );

endmodule

// File: tb/sim_pwm_channel.sv
module sim_pwm_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic [3:0]  cfg_csel = '0;
    logic [3:0]  cfg_diva_tap = '0;
    logic [7:0]  cfg_diva = '0;
    logic [3:0]  cfg_divb_tap = '0;
    logic [7:0]  cfg_divb = '0;
    logic [15:0] cfg_period = '0;
    logic [15:0] cfg_duty = '0;
    logic        cfg_pol = 1'b0;
    logic        cfg_center = 1'b0;
    logic        pwm_out;
    logic        period_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cur_pol = 1'b0;

    typedef struct {
        int    per;
        int    act;
        string tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    pwm_channel u0 (
        .clk          (clk),
        .rst          (rst),
        .cfg_en       (cfg_en),
        .cfg_csel     (cfg_csel),
        .cfg_diva_tap (cfg_diva_tap),
        .cfg_diva     (cfg_diva),
        .cfg_divb_tap (cfg_divb_tap),
        .cfg_divb     (cfg_divb),
        .cfg_period   (cfg_period),
        .cfg_duty     (cfg_duty),
        .cfg_pol      (cfg_pol),
        .cfg_center   (cfg_center),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(input int csel, input int at, input int ad,
                                input int bt, input int bd, input int p,
                                input int d, input bit ctr, input string tag);
        exp_t e;
        int x;
        int pe;
        pe = (p == 0) ? 1 : p;
        if (csel < 11)       x = 1 << csel;
        else if (csel == 11) x = (1 << at) * ad;
        else                 x = (1 << bt) * bd;
        e.per = x * (ctr ? 2 * pe : pe);
        e.act = (d >= pe) ? 0 : x * (ctr ? 2 * (pe - d) : (pe - d));
        e.tag = tag;
        return e;
    endfunction

    task automatic wait_drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic setup(input int csel, input int at, input int ad, input int bt,
                         input int bd, input int p, input int d, input bit pol,
                         input bit ctr);
        @(negedge clk);
        cfg_en       = 1'b0;
        cfg_csel     = 4'(csel);
        cfg_diva_tap = 4'(at);
        cfg_diva     = 8'(ad);
        cfg_divb_tap = 4'(bt);
        cfg_divb     = 8'(bd);
        cfg_period   = 16'(p);
        cfg_duty     = 16'(d);
        cfg_pol      = pol;
        cfg_center   = ctr;
        cur_pol      = pol;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(input int csel, input int at, input int ad, input int bt,
                            input int bd, input int p, input int d, input bit pol,
                            input bit ctr, input int n, input string tag);
        setup(csel, at, ad, bt, bd, p, d, pol, ctr);
        for (int i = 0; i < n; i++) q.push_back(mk(csel, at, ad, bt, bd, p, d, ctr, tag));
        cfg_en = 1'b1;
        wait_drain();
        @(negedge clk);
        cfg_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: measure each period between markers and score it.
    initial begin
        bit have_prev;
        int cyc;
        int nact;
        exp_t e;
        have_prev = 1'b0;
        cyc = 0;
        nact = 0;
        forever begin
            @(negedge clk);
            if (rst || !cfg_en) begin
                have_prev = 1'b0;
            end else begin
                if (period_start) begin
                    if (have_prev && q.size() > 0) begin
                        e = q.pop_front();
                        chk(e.tag, "period cycles", cyc, e.per);
                        chk(e.tag, "opposite-level cycles", nact, e.act);
                    end
                    have_prev = 1'b1;
                    cyc = 0;
                    nact = 0;
                end
                if (have_prev) begin
                    cyc++;
                    if (pwm_out != cur_pol) nact++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "pwm_out in reset", int'(pwm_out), 0);
        chk("R1", "period_start in reset", int'(period_start), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "pwm_out after reset", int'(pwm_out), 0);

        // R2 R4 edge-aligned on fast tap, start level low
        run_case(0, 0, 0, 0, 0, 5, 2, 1'b0, 1'b0, 3, "R4");
        // R2 R6 tap 8, start level high
        run_case(3, 0, 0, 0, 0, 4, 1, 1'b1, 1'b0, 2, "R6");
        // R5 center-aligned on tap 2
        run_case(1, 0, 0, 0, 0, 4, 1, 1'b0, 1'b1, 3, "R5");
        // R9 R5 zero duty in center mode: constant opposite level
        run_case(0, 0, 0, 0, 0, 3, 0, 1'b0, 1'b1, 2, "R9");
        // R9 duty equal to period: constant start level
        run_case(2, 0, 0, 0, 0, 6, 6, 1'b1, 1'b0, 2, "R9");
        // R3 divider A: tap 2 times 3
        run_case(11, 1, 3, 0, 0, 3, 1, 1'b0, 1'b0, 2, "R3");
        // R3 divider B: tap 1 times 5, center mode
        run_case(12, 0, 0, 0, 5, 2, 1, 1'b1, 1'b1, 2, "R3");
        // R11 period zero behaves as one; R10 marker every cycle
        run_case(0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 3, "R11");
        // R2 slowest tap
        run_case(10, 0, 0, 0, 0, 1, 0, 1'b0, 1'b0, 2, "R2");

        // R7 shadowed period and duty
        setup(0, 0, 0, 0, 0, 6, 2, 1'b0, 1'b0);
        q.push_back(mk(0, 0, 0, 0, 0, 6, 2, 1'b0, "R7"));
        cfg_en = 1'b1;
        wait_drain();
        q.push_back(mk(0, 0, 0, 0, 0, 6, 2, 1'b0, "R7"));
        q.push_back(mk(0, 0, 0, 0, 0, 8, 2, 1'b0, "R7"));
        q.push_back(mk(0, 0, 0, 0, 0, 8, 2, 1'b0, "R7"));
        @(negedge clk);
        @(negedge clk);
        cfg_period = 16'd8;
        wait_drain();

        // R8 disabled: idle at start level, no markers
        @(negedge clk);
        cfg_pol = 1'b1;
        cur_pol = 1'b1;
        cfg_en  = 1'b0;
        @(negedge clk);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            if (pwm_out != 1'b1 || period_start) seen++;
            @(negedge clk);
        end
        chk("R8", "idle cycles off start level or marked", seen, 0);
        cfg_pol = 1'b0;
        @(negedge clk);
        chk("R8", "idle level follows start level", int'(pwm_out), 0);

        // R3 unused select code: no advance
        setup(13, 0, 0, 0, 0, 2, 1, 1'b0, 1'b0);
        cfg_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (period_start) seen++;
        end
        chk("R3", "markers with select code 13", seen, 0);
        chk("R3", "output held at start level", int'(pwm_out), 0);

        // R3 divider with divide value zero
        setup(11, 0, 0, 0, 0, 2, 1, 1'b0, 1'b0);
        cfg_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (period_start) seen++;
        end
        chk("R3", "markers with divide value 0", seen, 0);
        cfg_en = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule